// File: doc/BRIEF.md
# CAN Acceptance Filter Bank Array

This block decides whether a received CAN frame identifier is kept, and where it goes. It holds an array of filter banks. Each bank carries two 32-bit filter words and four control bits: active, list-or-mask mode, 32-or-16-bit scale and receive-FIFO select. A bank in 32-bit scale holds either one masked filter or two exact-match entries. A bank in 16-bit scale holds either two masked filters or four exact-match entries.

A frame identifier arrives as a 32-bit compare word with a valid strobe and a controller select. The bank array is split by a programmable index into a lower group, which serves controller 0, and an upper group, which serves controller 1. Only active banks in the selected group take part in matching. One cycle later the block reports the following:
- whether the frame was accepted;
- the FIFO it goes to;
- the winning bank;
- a filter match index that numbers filter slots per FIFO inside the group.

Configuration is loaded through a simple word-write port while an init flag is held high.

Top module: `can_acc_filter`

## Requirements
- R1: `acc_valid` is high exactly in the cycle after a cycle with `id_valid` high; the result outputs are registered. Whenever `acc_hit` is 0, `acc_fifo`, `acc_bank` and `acc_fmi` are 0. After reset, `acc_valid` and `acc_hit` are 0, every bank is inactive and all filter words are 0.
- R2: The 32-bit compare word carries IDE at bit 2 (1 = extended) and RTR at bit 1 (1 = remote). It holds a standard identifier at bits 31:21 or an extended identifier at bits 31:3. A 32-bit mask bank accepts when (word & word2) == (word1 & word2), where word1 is the identifier and word2 is the mask.
- R3: A 32-bit list bank accepts only a compare word exactly equal to word1 (slot 0) or word2 (slot 1).
- R4: The 16-bit compare word is built from the 32-bit word as follows:
  - bits 15:5 are word bits 31:21;
  - bit 4 is RTR;
  - bit 3 is IDE;
  - bits 2:0 are word bits 20:18 when IDE is 1, and 0 otherwise.
  A 16-bit mask bank has filter slot 0 in word1 and slot 1 in word2, each with the identifier in bits 15:0 and the mask in bits 31:16.
- R5: A 16-bit list bank holds four exact entries: slot 0 is word1[15:0], slot 1 is word1[31:16], slot 2 is word2[15:0] and slot 3 is word2[31:16]. Within a bank the lowest matching slot is reported.
- R6: Only banks whose active bit is 1 take part in matching. A frame that no active bank accepts gives `acc_hit` = 0.
- R7: When several banks accept a frame, the lowest-indexed bank wins. `acc_fifo` is that bank's FIFO bit (0 = FIFO 0, 1 = FIFO 1).
- R8: With `id_ctl` = 0, only banks below the split index take part; with `id_ctl` = 1, only banks at or above it take part. The split index resets to 14.
- R9: The configuration port writes one 32-bit word per cycle, and only while `init_mode` is 1; a write with `init_mode` 0 has no effect. Addresses:
  - 0: split index;
  - 1: mode vector (bit b = 1 means bank b is list);
  - 2: scale vector (1 = 32-bit);
  - 3: FIFO vector;
  - 4: active vector;
  - 64+2b: word1 of bank b;
  - 65+2b: word2 of bank b.
- R10: `acc_fmi` is the sum of the filter slots of every lower-indexed bank in the same group with the same FIFO bit, active or not, plus the winning slot number. A bank counts 1 slot for 32-bit mask, 2 for 32-bit list, 2 for 16-bit mask and 4 for 16-bit list.
- R11: A frame sampled while `init_mode` is 1 gives `acc_hit` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_mode | input | 1 | Configuration mode; enables writes and blocks acceptance |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| id_valid | input | 1 | Compare word valid strobe |
| id_ctl | input | 1 | Controller select: 0 lower bank group, 1 upper group |
| id_word | input | 32 | Received identifier in 32-bit compare-word layout |
| acc_valid | output | 1 | Result valid, one cycle after id_valid |
| acc_hit | output | 1 | Frame accepted |
| acc_fifo | output | 1 | Target FIFO of the accepting bank |
| acc_bank | output | BANK_W | Index of the winning bank |
| acc_fmi | output | FMI_W | Filter match index within FIFO and group |

## Verification
The assertions assume three things about the configuration:
- it changes only in cycles where `init_mode` is high, so a reported winner can be compared against the live active, FIFO and split state of the cycle after the frame;
- a reported bank index always names an existing bank;
- the controller select is stable alongside its strobe.

The stimulus follows these assumptions. Every configuration write is made inside an init window, and frames are offered only after init drops, except for the single frame that deliberately probes the init block. A write made with init low is issued only to show that it is ignored.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

    // Configuration word addresses
    localparam int ADDR_SPLIT  = 0;
    localparam int ADDR_MODE   = 1;
    localparam int ADDR_SCALE  = 2;
    localparam int ADDR_FIFO   = 3;
    localparam int ADDR_ACTIVE = 4;
    localparam int FILT_BASE   = 64;

    // Per-bank configuration
    typedef struct packed {
        logic        active;
        logic        list_mode;  // 1 = exact list, 0 = id/mask
        logic        scale32;    // 1 = 32-bit, 0 = 16-bit
        logic        fifo1;      // 1 = FIFO 1
        logic [31:0] word1;
        logic [31:0] word2;
    } bank_cfg_t;

    typedef struct packed {
        logic       hit;
        logic [1:0] slot;
    } slot_hit_t;

    // Build the 16-bit compare word from the 32-bit one
    function automatic logic [15:0] to_half(input logic [31:0] w);
        return {w[31:21], w[1], w[2], w[20:18] & {3{w[2]}}};
    endfunction

    // Number of filter slots a bank occupies
    function automatic logic [2:0] slot_count(input logic list_mode, input logic scale32);
        logic [2:0] n;
        case ({scale32, list_mode})
            2'b10:   n = 3'd1;
            2'b11:   n = 3'd2;
            2'b00:   n = 3'd2;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

    // Evaluate one bank against a compare word; lowest matching slot wins
    function automatic slot_hit_t eval_bank(input bank_cfg_t c, input logic [31:0] w);
        logic [15:0] h;
        logic [3:0]  m;
        slot_hit_t   r;
        h = to_half(w);
        case ({c.scale32, c.list_mode})
            2'b11: m = {2'b00, w == c.word2, w == c.word1};
            2'b10: m = {3'b000, ((w ^ c.word1) & c.word2) == 32'd0};
            2'b01: m = {h == c.word2[31:16], h == c.word2[15:0],
                        h == c.word1[31:16], h == c.word1[15:0]};
            default: m = {2'b00,
                          ((h ^ c.word2[15:0]) & c.word2[31:16]) == 16'd0,
                          ((h ^ c.word1[15:0]) & c.word1[31:16]) == 16'd0};
        endcase
        r.hit  = |m;
        r.slot = m[0] ? 2'd0 : m[1] ? 2'd1 : m[2] ? 2'd2 : 2'd3;
        return r;
    endfunction

endpackage

// File: rtl/can_filt_cfg.sv
module can_filt_cfg
    import can_filt_pkg::*;
#(
    parameter int NUM_BANKS   = 28,
    parameter int SPLIT_RESET = 14,
    parameter int ADDR_W      = 7,
    parameter int SPLIT_W     = 5
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            init_mode,
    input  logic                            cfg_we,
    input  logic [ADDR_W-1:0]               cfg_addr,
    input  logic [31:0]                     cfg_wdata,
    output bank_cfg_t [NUM_BANKS-1:0]       cfg,
    output logic [SPLIT_W-1:0]              split
);
    localparam logic [ADDR_W-1:0] A_SPLIT  = ADDR_W'(ADDR_SPLIT);
    localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(ADDR_MODE);
    localparam logic [ADDR_W-1:0] A_SCALE  = ADDR_W'(ADDR_SCALE);
    localparam logic [ADDR_W-1:0] A_FIFO   = ADDR_W'(ADDR_FIFO);
    localparam logic [ADDR_W-1:0] A_ACTIVE = ADDR_W'(ADDR_ACTIVE);

    logic                 wr_ok;
    logic [NUM_BANKS-1:0] mode_q, scale_q, fifo_q, act_q;
    logic [SPLIT_W-1:0]   split_q;

    assign wr_ok = cfg_we & init_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            scale_q <= '0;
            fifo_q  <= '0;
            act_q   <= '0;
            split_q <= SPLIT_W'(SPLIT_RESET);
        end else if (wr_ok) begin
            if (cfg_addr == A_SPLIT)  split_q <= cfg_wdata[SPLIT_W-1:0];
            if (cfg_addr == A_MODE)   mode_q  <= cfg_wdata[NUM_BANKS-1:0];
            if (cfg_addr == A_SCALE)  scale_q <= cfg_wdata[NUM_BANKS-1:0];
            if (cfg_addr == A_FIFO)   fifo_q  <= cfg_wdata[NUM_BANKS-1:0];
            if (cfg_addr == A_ACTIVE) act_q   <= cfg_wdata[NUM_BANKS-1:0];
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] A_W1 = ADDR_W'(FILT_BASE + 2 * b);
        localparam logic [ADDR_W-1:0] A_W2 = ADDR_W'(FILT_BASE + 2 * b + 1);
        logic [31:0] w1_q, w2_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                w1_q <= '0;
                w2_q <= '0;
            end else if (wr_ok) begin
                if (cfg_addr == A_W1) w1_q <= cfg_wdata;
                if (cfg_addr == A_W2) w2_q <= cfg_wdata;
            end
        end

        assign cfg[b] = '{active: act_q[b], list_mode: mode_q[b], scale32: scale_q[b],
                          fifo1: fifo_q[b], word1: w1_q, word2: w2_q};
    end

    assign split = split_q;
endmodule

// File: rtl/can_filt_match.sv
module can_filt_match
    import can_filt_pkg::*;
#(
    parameter int NUM_BANKS = 28,
    parameter int SPLIT_W   = 5
) (
    input  bank_cfg_t [NUM_BANKS-1:0]   cfg,
    input  logic [SPLIT_W-1:0]          split,
    input  logic                        ctl_sel,
    input  logic [31:0]                 word,
    output logic [NUM_BANKS-1:0]        hit,
    output logic [NUM_BANKS-1:0][1:0]   slot,
    output logic [NUM_BANKS-1:0]        grp_hi
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
        slot_hit_t r;
        assign r         = eval_bank(cfg[b], word);
        assign grp_hi[b] = (b >= int'(split));
        assign hit[b]    = r.hit & cfg[b].active & (grp_hi[b] == ctl_sel);
        assign slot[b]   = r.slot;
    end
endmodule

// File: rtl/can_filt_select.sv
module can_filt_select
    import can_filt_pkg::*;
#(
    parameter int NUM_BANKS = 28,
    parameter int BANK_W    = 5,
    parameter int FMI_W     = 7
) (
    input  bank_cfg_t [NUM_BANKS-1:0]   cfg,
    input  logic [NUM_BANKS-1:0]        hit,
    input  logic [NUM_BANKS-1:0][1:0]   slot,
    input  logic [NUM_BANKS-1:0]        grp_hi,
    output logic                        found,
    output logic                        fifo,
    output logic [BANK_W-1:0]           bank,
    output logic [FMI_W-1:0]            fmi
);
    int         win;
    logic       wfifo, wgrp;
    logic [1:0] wslot;
    logic [FMI_W-1:0] base;

    always_comb begin
        found = 1'b0;
        win   = 0;
        wfifo = 1'b0;
        wgrp  = 1'b0;
        wslot = 2'd0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit[b] && !found) begin
                found = 1'b1;
                win   = b;
                wfifo = cfg[b].fifo1;
                wgrp  = grp_hi[b];
                wslot = slot[b];
            end
        end
        base = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (b < win && cfg[b].fifo1 == wfifo && grp_hi[b] == wgrp)
                base = base + FMI_W'(slot_count(cfg[b].list_mode, cfg[b].scale32));
        end
        fifo = found & wfifo;
        bank = found ? BANK_W'(win) : '0;
        fmi  = found ? base + FMI_W'(wslot) : '0;
    end
endmodule

// File: rtl/can_acc_filter.sv
module can_acc_filter
    import can_filt_pkg::*;
#(
    parameter int NUM_BANKS   = 28,
    parameter int SPLIT_RESET = 14,
    parameter int ADDR_W      = 7,
    localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int FMI_W      = $clog2(4 * NUM_BANKS),
    localparam int SPLIT_W    = $clog2(NUM_BANKS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               init_mode,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [31:0]        cfg_wdata,
    input  logic               id_valid,
    input  logic               id_ctl,
    input  logic [31:0]        id_word,
    output logic               acc_valid,
    output logic               acc_hit,
    output logic               acc_fifo,
    output logic [BANK_W-1:0]  acc_bank,
    output logic [FMI_W-1:0]   acc_fmi
);
    bank_cfg_t [NUM_BANKS-1:0]  cfg;
    logic [SPLIT_W-1:0]         split_q;
    logic [NUM_BANKS-1:0]       hit, grp_hi, act_vec, fifo_vec;
    logic [NUM_BANKS-1:0][1:0]  slot;
    logic                       found, sel_fifo;
    logic [BANK_W-1:0]          sel_bank;
    logic [FMI_W-1:0]           sel_fmi;

    can_filt_cfg #(
        .NUM_BANKS(NUM_BANKS), .SPLIT_RESET(SPLIT_RESET),
        .ADDR_W(ADDR_W), .SPLIT_W(SPLIT_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .init_mode(init_mode), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg(cfg), .split(split_q)
    );

    can_filt_match #(.NUM_BANKS(NUM_BANKS), .SPLIT_W(SPLIT_W)) u_match (
        .cfg(cfg), .split(split_q), .ctl_sel(id_ctl), .word(id_word),
        .hit(hit), .slot(slot), .grp_hi(grp_hi)
    );

    can_filt_select #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .FMI_W(FMI_W)) u_sel (
        .cfg(cfg), .hit(hit), .slot(slot), .grp_hi(grp_hi),
        .found(found), .fifo(sel_fifo), .bank(sel_bank), .fmi(sel_fmi)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_vec
        assign act_vec[b]  = cfg[b].active;
        assign fifo_vec[b] = cfg[b].fifo1;
    end

    logic take;
    assign take = id_valid & ~init_mode & found;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_valid <= 1'b0;
            acc_hit   <= 1'b0;
            acc_fifo  <= 1'b0;
            acc_bank  <= '0;
            acc_fmi   <= '0;
        end else begin
            acc_valid <= id_valid;
            acc_hit   <= take;
            acc_fifo  <= take & sel_fifo;
            acc_bank  <= take ? sel_bank : '0;
            acc_fmi   <= take ? sel_fmi : '0;
        end
    end
endmodule

// File: rtl/can_acc_filter_chk.sv
module can_acc_filter_chk #(
    parameter int NUM_BANKS = 28,
    parameter int BANK_W    = 5,
    parameter int FMI_W     = 7,
    parameter int SPLIT_W   = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 init_mode,
    input logic                 id_valid,
    input logic                 id_ctl,
    input logic                 acc_valid,
    input logic                 acc_hit,
    input logic                 acc_fifo,
    input logic [BANK_W-1:0]    acc_bank,
    input logic [FMI_W-1:0]     acc_fmi,
    input logic [NUM_BANKS-1:0] act_vec,
    input logic [NUM_BANKS-1:0] fifo_vec,
    input logic [SPLIT_W-1:0]   split
);
    localparam int PAD = 2 ** BANK_W;
    logic [PAD-1:0] act_pad, fifo_pad;
    assign act_pad  = PAD'(act_vec);
    assign fifo_pad = PAD'(fifo_vec);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        id_valid |=> acc_valid);
    // R1
    valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !id_valid |=> !acc_valid);
    // R1
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_hit |-> (acc_bank == '0 && acc_fmi == '0 && !acc_fifo));
    // R6
    winner_active_chk: assert property (@(posedge clk) disable iff (rst)
        acc_hit |-> (acc_valid && act_pad[acc_bank]));
    // R7
    fifo_route_chk: assert property (@(posedge clk) disable iff (rst)
        acc_hit |-> (acc_fifo == fifo_pad[acc_bank]));
    // R8
    group_sel_chk: assert property (@(posedge clk) disable iff (rst)
        acc_hit |-> ((int'(acc_bank) >= int'(split)) == $past(id_ctl)));
    // R11
    init_block_chk: assert property (@(posedge clk) disable iff (rst)
        init_mode |=> !acc_hit);
endmodule

bind can_acc_filter can_acc_filter_chk #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .FMI_W(FMI_W), .SPLIT_W(SPLIT_W)
) chk (
    .clk(clk), .rst(rst), .init_mode(init_mode), .id_valid(id_valid), .id_ctl(id_ctl),
    .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_fifo(acc_fifo), .acc_bank(acc_bank),
    .acc_fmi(acc_fmi), .act_vec(act_vec), .fifo_vec(fifo_vec), .split(split_q)
);

// File: tb/can_acc_filter_test.sv
module can_acc_filter_test;
    localparam int NV = 21;

    typedef struct packed {
        logic        ctl;
        logic [31:0] word;
        logic        hit;
        logic        fifo;
        logic [7:0]  bank;
        logic [7:0]  fmi;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h24A00000, 1'b1, 1'b0, 8'd0,  8'd0},
        '{1'b0, 32'h25E00002, 1'b1, 1'b0, 8'd0,  8'd0},
        '{1'b0, 32'h24A00004, 1'b0, 1'b0, 8'd0,  8'd0},
        '{1'b0, 32'h40000000, 1'b1, 1'b1, 8'd1,  8'd0},
        '{1'b0, 32'h40000002, 1'b0, 1'b0, 8'd0,  8'd0},
        '{1'b0, 32'h055E6F7C, 1'b1, 1'b1, 8'd1,  8'd1},
        '{1'b0, 32'h60200000, 1'b1, 1'b0, 8'd2,  8'd2},
        '{1'b0, 32'h60400002, 1'b1, 1'b0, 8'd2,  8'd3},
        '{1'b0, 32'h60400000, 1'b0, 1'b0, 8'd0,  8'd0},
        '{1'b0, 32'h60600000, 1'b1, 1'b0, 8'd2,  8'd4},
        '{1'b0, 32'h60000000, 1'b1, 1'b0, 8'd2,  8'd1},
        '{1'b0, 32'h80000002, 1'b1, 1'b1, 8'd3,  8'd2},
        '{1'b0, 32'hA0000002, 1'b1, 1'b1, 8'd3,  8'd3},
        '{1'b0, 32'hA0000000, 1'b0, 1'b0, 8'd0,  8'd0},
        '{1'b0, 32'h80000004, 1'b0, 1'b0, 8'd0,  8'd0},
        '{1'b1, 32'h24A00000, 1'b1, 1'b1, 8'd14, 8'd0},
        '{1'b0, 32'hFFE00000, 1'b0, 1'b0, 8'd0,  8'd0},
        '{1'b0, 32'hC0140004, 1'b1, 1'b1, 8'd6,  8'd5},
        '{1'b0, 32'hC0100004, 1'b0, 1'b0, 8'd0,  8'd0},
        '{1'b0, 32'hC0140000, 1'b1, 1'b1, 8'd6,  8'd6},
        '{1'b0, 32'h00000000, 1'b1, 1'b1, 8'd6,  8'd7}
    };

    string vec_tag [NV] = '{"R7", "R2", "R2", "R3", "R3", "R3", "R5", "R5", "R5", "R5",
                            "R10", "R4", "R4", "R4", "R4", "R8", "R8", "R4", "R4", "R4",
                            "R10"};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        id_valid = 1'b0;
    logic        id_ctl = 1'b0;
    logic [31:0] id_word = '0;
    logic        acc_valid, acc_hit, acc_fifo;
    logic [4:0]  acc_bank;
    logic [6:0]  acc_fmi;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    can_acc_filter uut (
        .clk(clk), .rst(rst), .init_mode(init_mode), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .id_valid(id_valid),
        .id_ctl(id_ctl), .id_word(id_word), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .acc_fifo(acc_fifo), .acc_bank(acc_bank), .acc_fmi(acc_fmi)
    );

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic ctl, input logic [31:0] w);
        @(negedge clk);
        id_valid = 1'b1; id_ctl = ctl; id_word = w;
        @(negedge clk);
        id_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic v, input logic h, input logic f,
                              input logic [7:0] b, input logic [7:0] m);
        logic [18:0] act, exp;
        act = {acc_valid, acc_hit, acc_fifo, 8'(acc_bank), 8'(acc_fmi)};
        exp = {v, h, f, b, m};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of outputs
        expect_out("R1 reset", 1'b0, 1'b0, 1'b0, 8'd0, 8'd0);
        rst = 1'b0;
        @(negedge clk);
        expect_out("R1 after reset", 1'b0, 1'b0, 1'b0, 8'd0, 8'd0);

        // R6: no bank active after reset, so every frame is discarded
        send(1'b0, 32'h00000000);
        expect_out("R6 none active", 1'b1, 1'b0, 1'b0, 8'd0, 8'd0);
        @(negedge clk);
        expect_out("R1 valid drops", 1'b0, 1'b0, 1'b0, 8'd0, 8'd0);

        // R9: load configuration inside an init window
        init_mode = 1'b1;
        wr(1, 32'h00000046);
        wr(2, 32'h00004033);
        wr(3, 32'h0000406A);
        wr(4, 32'h0000406F);
        wr(64, 32'h24600000); wr(65, 32'hFE000004);
        wr(66, 32'h40000000); wr(67, 32'h055E6F7C);
        wr(68, 32'h60206000); wr(69, 32'h60606050);
        wr(70, 32'hFFE88000); wr(71, 32'hFFF8A010);
        wr(74, 32'h24A00000); wr(75, 32'hFFE00004);
        wr(76, 32'hC000C00D); wr(77, 32'h00000000);
        init_mode = 1'b0;

        for (int i = 0; i < NV; i++) begin
            send(VECS[i].ctl, VECS[i].word);
            expect_out(vec_tag[i], 1'b1, VECS[i].hit, VECS[i].fifo, VECS[i].bank, VECS[i].fmi);
        end

        // R9: write with init low is ignored
        wr(4, 32'h00000000);
        send(1'b0, 32'h24A00000);
        expect_out("R9 write ignored", 1'b1, 1'b1, 1'b0, 8'd0, 8'd0);

        // R11: no accept while init is high
        init_mode = 1'b1;
        send(1'b0, 32'h24A00000);
        expect_out("R11 init blocks", 1'b1, 1'b0, 1'b0, 8'd0, 8'd0);

        // R8: move split to the top; bank 14 joins group 0
        wr(0, 32'd28);
        init_mode = 1'b0;
        send(1'b0, 32'hFFE00000);
        expect_out("R8 split moved", 1'b1, 1'b1, 1'b1, 8'd14, 8'd9);
        send(1'b1, 32'h24A00000);
        expect_out("R8 empty group", 1'b1, 1'b0, 1'b0, 8'd0, 8'd0);

        // R7: drop bank 0, the next accepting bank takes the frame
        init_mode = 1'b1;
        wr(0, 32'd14);
        wr(4, 32'h0000406E);
        init_mode = 1'b0;
        send(1'b0, 32'h24A00000);
        expect_out("R7 fallback bank", 1'b1, 1'b1, 1'b1, 8'd5, 8'd4);

        // R6 / R10: activate accept-all bank 4; inactive bank 0 still counts slots
        init_mode = 1'b1;
        wr(4, 32'h0000407E);
        init_mode = 1'b0;
        send(1'b0, 32'hA0000000);
        expect_out("R6 activated", 1'b1, 1'b1, 1'b0, 8'd4, 8'd5);
        send(1'b0, 32'h24A00000);
        expect_out("R7 lower index", 1'b1, 1'b1, 1'b0, 8'd4, 8'd5);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule